// File: doc/BRIEF.md
# Endian-Configurable Data Memory Port

This block is a load/store port placed in front of a byte-addressed RAM of 2^MEM_LOG2 bytes. One request per cycle may be presented: a byte, 16-bit or 32-bit read or write. The port maps the request address onto the RAM, orders the bytes of a multi-byte access by a static endianness input, and returns read data one cycle later. Reads can return the byte or halfword zero-extended or sign-extended.

Addresses are never rejected. Bits that lie above the implemented size, and low bits that break the natural alignment of a 16-bit or 32-bit access, are cleared before the RAM is touched. Each such bit raises a bus-error flag alongside the response, so the access goes through and the error is reported at the same time. A byte write above a fixed I/O base address also raises an I/O-window flag, so that logic outside the block can forward that byte to a peripheral.

Top module: `endian_mem_port`

## Requirements
- R1: The RAM holds 2^MEM_LOG2 bytes, with MEM_LOG2 between 1 and 24. A byte access uses address bits [MEM_LOG2-1:0] as its effective address, so a byte access above the size reaches the byte at the wrapped address.
- R2: `req_size` encodes 0 = byte, 1 = 16-bit, 2 = 32-bit, and treats 3 as 32-bit. A 16-bit access clears address bit 0 and a 32-bit access clears bits 1 and 0 before the RAM is addressed.
- R3: `rsp_bus_err` is 1 when the request address has any bit set outside the mask of its size: a bit at or above MEM_LOG2, bit 0 for a 16-bit access, or bit 1 or 0 for a 32-bit access. Otherwise it is 0.
- R4: A write that raises a bus error still writes its data at the masked address.
- R5: With `big_endian` = 0, the byte at the lowest address of a 16-bit or 32-bit access carries bits [7:0], and each higher address carries the next byte up.
- R6: With `big_endian` = 1, the byte at the lowest address carries the most significant byte of the 16-bit or 32-bit value, and each higher address carries the next byte down.
- R7: Byte reads and byte writes give the same result for both values of `big_endian`.
- R8: With `req_signed` = 1, a byte read is sign-extended from bit 7 and a 16-bit read from bit 15. With `req_signed` = 0 both are zero-extended. A 32-bit read is returned unchanged.
- R9: `rsp_io_win` is 1 only for a byte write whose unsigned address is greater than 0x0500_0000. It is 0 for every read and for every 16-bit or 32-bit write.
- R10: `rsp_valid`, `rsp_rdata`, `rsp_bus_err` and `rsp_io_win` belong to the request accepted on the previous rising edge. `rsp_valid` is 0 in a cycle that follows an idle cycle, and `rsp_rdata` is 0 in the response to a write.
- R11: While `rst_n` is low at a rising edge, all response outputs are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| big_endian | input | 1 | Static byte-order select: 1 = most significant byte first |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 or 3 32-bit |
| req_signed | input | 1 | Sign-extend byte and 16-bit reads |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, extended to 32 bits |
| rsp_bus_err | output | 1 | Address had bits outside its size mask |
| rsp_io_win | output | 1 | Byte write above the I/O base address |

## Verification
An error in the mask for one size shows up in the response to the first access of that size at an offending address: the wrong bus-error value, and for an effective address that fails to wrap or align, read data taken from the wrong byte. An error in lane order or in the byte enables leaves the RAM in a wrong state. That state appears one cycle after the next read that covers those bytes. This read can be much later than the write, so the bench follows every write pattern with reads of every address, of every size, in both byte orders, before it moves on.

// File: rtl/mport_pkg.sv
// Shared types and constants for the data memory port.
// Assumes accesses are at most four bytes wide.
package mport_pkg;

    localparam int LANES = 4;

    // Access size code as carried on req_size; code 3 acts as a 32-bit access.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef logic [LANES-1:0][7:0] lane_bytes_t;

endpackage

// File: rtl/mport_addr.sv
// Address stage: picks the mask for the access size, forms the effective
// RAM address, flags bus errors and flags byte writes in the I/O window.
// Assumes MEM_LOG2 < ADDR_W.
module mport_addr
    import mport_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          MEM_LOG2 = 10,
    parameter logic [31:0] IO_BASE  = 32'h0500_0000
) (
    input  logic [ADDR_W-1:0]   addr,
    input  acc_size_e           size,
    input  logic                write,
    output logic [MEM_LOG2-1:0] eff_addr,
    output logic                bus_err,
    output logic                io_hit
);

    localparam logic [ADDR_W-1:0] BYTE_MASK = ADDR_W'((64'd1 << MEM_LOG2) - 64'd1);

    logic [ADDR_W-1:0] mask;

    // Mask for the access size: byte, then 16-bit and 32-bit alignment.
    always_comb begin
        case (size)
            SZ_BYTE: mask = BYTE_MASK;
            SZ_HALF: mask = BYTE_MASK & ~ADDR_W'(1);
            default: mask = BYTE_MASK & ~ADDR_W'(3);
        endcase
    end

    // Effective address and status flags.
    always_comb begin
        eff_addr = addr[MEM_LOG2-1:0] & mask[MEM_LOG2-1:0];
        bus_err  = |(addr & ~mask);
        io_hit   = write && (size == SZ_BYTE) && (32'(addr) > IO_BASE);
    end

endmodule

// File: rtl/mport_ram.sv
// Byte-wide RAM with four byte lanes starting at a base address. Each lane
// address wraps at the RAM size. The read is combinational and the write
// lands on the rising edge. Contents are not reset.
module mport_ram
    import mport_pkg::*;
#(
    parameter int MEM_LOG2 = 10
) (
    input  logic                clk,
    input  logic [MEM_LOG2-1:0] base,
    input  logic [LANES-1:0]    wen,
    input  lane_bytes_t         wbytes,
    output lane_bytes_t         rbytes
);

    localparam int DEPTH = 1 << MEM_LOG2;

    logic [7:0]                      mem [DEPTH];
    logic [LANES-1:0][MEM_LOG2-1:0]  idx;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane address with wrap-around, and its read value.
        assign idx[g]    = base + MEM_LOG2'(g);
        assign rbytes[g] = mem[idx[g]];
    end

    // Write the enabled byte lanes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (wen[i]) mem[idx[i]] <= wbytes[i];
        end
    end

endmodule

// File: rtl/mport_lanes.sv
// Byte-lane steering. The write side spreads right-aligned write data over
// lanes in address order and sets their enables. The read side gathers
// lanes into a right-aligned value and extends it. Purely combinational.
module mport_lanes
    import mport_pkg::*;
(
    input  acc_size_e    wr_size,
    input  logic         wr_big,
    input  logic [31:0]  wr_data,
    output logic [3:0]   wr_en,
    output lane_bytes_t  wr_bytes,
    input  acc_size_e    rd_size,
    input  logic         rd_big,
    input  logic         rd_signed,
    input  lane_bytes_t  rd_bytes,
    output logic [31:0]  rd_data
);

    // Spread write data over the lanes according to size and byte order.
    always_comb begin
        wr_bytes = '0;
        case (wr_size)
            SZ_BYTE: begin
                wr_en       = 4'b0001;
                wr_bytes[0] = wr_data[7:0];
            end
            SZ_HALF: begin
                wr_en       = 4'b0011;
                wr_bytes[0] = wr_big ? wr_data[15:8] : wr_data[7:0];
                wr_bytes[1] = wr_big ? wr_data[7:0]  : wr_data[15:8];
            end
            default: begin
                wr_en = 4'b1111;
                for (int i = 0; i < LANES; i++) begin
                    wr_bytes[i] = wr_big ? wr_data[8*(LANES-1-i) +: 8] : wr_data[8*i +: 8];
                end
            end
        endcase
    end

    // Gather read lanes and extend the result to 32 bits.
    always_comb begin
        logic [15:0] half;
        half = rd_big ? {rd_bytes[0], rd_bytes[1]} : {rd_bytes[1], rd_bytes[0]};
        case (rd_size)
            SZ_BYTE: rd_data = {{24{rd_signed & rd_bytes[0][7]}}, rd_bytes[0]};
            SZ_HALF: rd_data = {{16{rd_signed & half[15]}}, half};
            default: rd_data = rd_big
                ? {rd_bytes[0], rd_bytes[1], rd_bytes[2], rd_bytes[3]}
                : {rd_bytes[3], rd_bytes[2], rd_bytes[1], rd_bytes[0]};
        endcase
    end

endmodule

// File: rtl/endian_mem_port.sv
// Load/store port in front of a 2^MEM_LOG2-byte RAM. It accepts one request
// per cycle and responds on the next cycle. A write that raises a bus error
// still writes its masked address. big_endian is expected to change only
// while no request is in flight.
module endian_mem_port
    import mport_pkg::*;
#(
    parameter int          MEM_LOG2 = 10,
    parameter logic [31:0] IO_BASE  = 32'h0500_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        big_endian,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic        req_signed,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_bus_err,
    output logic        rsp_io_win
);

    localparam int ADDR_W = 32;

    acc_size_e           size_in;
    logic [MEM_LOG2-1:0] eff_addr;
    logic                bus_err, io_hit;
    logic [3:0]          lane_en;
    lane_bytes_t         lane_wr, lane_rd, lane_rd_q;
    acc_size_e           size_q;
    logic                read_q, signed_q, big_q;
    logic [31:0]         rd_ext;

    assign size_in = acc_size_e'(req_size);

    mport_addr #(.ADDR_W(ADDR_W), .MEM_LOG2(MEM_LOG2), .IO_BASE(IO_BASE)) i_addr (
        .addr     (req_addr),
        .size     (size_in),
        .write    (req_write),
        .eff_addr (eff_addr),
        .bus_err  (bus_err),
        .io_hit   (io_hit)
    );

    mport_ram #(.MEM_LOG2(MEM_LOG2)) i_ram (
        .clk    (clk),
        .base   (eff_addr),
        .wen    (lane_en & {LANES{req_valid & req_write}}),
        .wbytes (lane_wr),
        .rbytes (lane_rd)
    );

    mport_lanes i_lanes (
        .wr_size   (size_in),
        .wr_big    (big_endian),
        .wr_data   (req_wdata),
        .wr_en     (lane_en),
        .wr_bytes  (lane_wr),
        .rd_size   (size_q),
        .rd_big    (big_q),
        .rd_signed (signed_q),
        .rd_bytes  (lane_rd_q),
        .rd_data   (rd_ext)
    );

    // Response register: flags, raw read lanes and read attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_bus_err <= 1'b0;
            rsp_io_win  <= 1'b0;
            read_q      <= 1'b0;
            signed_q    <= 1'b0;
            big_q       <= 1'b0;
            size_q      <= SZ_BYTE;
            lane_rd_q   <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_bus_err <= req_valid & bus_err;
            rsp_io_win  <= req_valid & io_hit;
            read_q      <= req_valid & ~req_write;
            signed_q    <= req_signed;
            big_q       <= big_endian;
            size_q      <= size_in;
            lane_rd_q   <= lane_rd;
        end
    end

    // Read data only in the response to a read.
    assign rsp_rdata = read_q ? rd_ext : 32'd0;

    // Checks on port behaviour over time.
    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid) else $error("response missing");                       // R10
    AST_IDLE_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid) else $error("response without request");             // R10
    AST_MISALIGNED_WORD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size[1] && req_addr[1:0] != 2'b00) |=> rsp_bus_err)
        else $error("misaligned word not flagged");                                     // R3
    AST_HIGH_ADDR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr >> MEM_LOG2) != 32'd0) |=> rsp_bus_err)
        else $error("out-of-range address not flagged");                                // R3
    AST_IO_ONLY_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(req_write && req_size == 2'd0)) |=> !rsp_io_win)
        else $error("I/O flag on a non-byte-write");                                    // R9
    AST_UNSIGNED_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'd0 && !req_signed) |=> (rsp_rdata[31:8] == 24'd0))
        else $error("unsigned byte not zero-extended");                                 // R8
    AST_SIGNED_HALF_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'd1 && req_signed) |=> (rsp_rdata[31:16] == {16{rsp_rdata[15]}}))
        else $error("signed half not sign-extended");                                   // R8
    AST_WRITE_NO_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == 32'd0))
        else $error("read data on write response");                                     // R10

endmodule

// File: tb/test_endian_mem_port.sv
// Self-checking bench on a 64-byte configuration. It uses a byte-array
// reference model and sweeps every address, size, sign mode and byte order.
module test_endian_mem_port;

    localparam int N     = 6;
    localparam int DEPTH = 1 << N;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_bus_err;
    logic        rsp_io_win;

    int total = 0;
    int bad = 0;
    logic [7:0] ref_mem [DEPTH];

    always #10 clk = ~clk;   // 50 MHz

    endian_mem_port #(.MEM_LOG2(N)) i_endian_mem_port (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_signed(req_signed), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_bus_err(rsp_bus_err), .rsp_io_win(rsp_io_win)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access with expected values from the reference model; updates the model on writes.
    task automatic access(input bit wr, input int sz, input bit sg, input logic [31:0] a,
                          input logic [31:0] wd, input string dtag);
        logic [31:0] emask, ea, exp_d;
        logic [7:0]  b [4];
        bit          err, io;
        emask = (sz == 0) ? 32'(DEPTH - 1) : (sz == 1) ? 32'(DEPTH - 2) : 32'(DEPTH - 4);
        err   = (a & ~emask) != 0;
        ea    = a & emask;
        io    = wr && sz == 0 && a > 32'h0500_0000;
        for (int i = 0; i < 4; i++) b[i] = ref_mem[(ea + 32'(i)) % DEPTH];
        if (sz == 0)
            exp_d = sg ? 32'($signed(b[0])) : {24'd0, b[0]};
        else if (sz == 1) begin
            exp_d = big_endian ? {16'd0, b[0], b[1]} : {16'd0, b[1], b[0]};
            if (sg && exp_d[15]) exp_d[31:16] = 16'hFFFF;
        end else
            exp_d = big_endian ? {b[0], b[1], b[2], b[3]} : {b[3], b[2], b[1], b[0]};
        if (wr) exp_d = 32'd0;

        @(negedge clk);
        chk("R10 idle", 32'(rsp_valid), 32'd0);
        req_valid = 1'b1; req_write = wr; req_size = 2'(sz);
        req_signed = sg; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 valid", 32'(rsp_valid), 32'd1);
        chk("R3", 32'(rsp_bus_err), 32'(err));
        chk("R9", 32'(rsp_io_win), 32'(io));
        chk(dtag, rsp_rdata, exp_d);

        if (wr) begin
            if (sz == 0) ref_mem[ea % DEPTH] = wd[7:0];
            else if (sz == 1) begin
                ref_mem[ea % DEPTH]       = big_endian ? wd[15:8] : wd[7:0];
                ref_mem[(ea + 1) % DEPTH] = big_endian ? wd[7:0]  : wd[15:8];
            end else
                for (int i = 0; i < 4; i++)
                    ref_mem[(ea + 32'(i)) % DEPTH] = big_endian ? wd[8*(3-i) +: 8] : wd[8*i +: 8];
        end
    endtask

    // Read every address with every size and sign mode in both byte orders.
    task automatic sweep_reads();
        for (int e = 0; e < 2; e++) begin
            big_endian = e[0];
            for (int a = 0; a < DEPTH; a++) begin
                for (int sz = 0; sz < 3; sz++) begin
                    for (int sg = 0; sg < 2; sg++) begin
                        string t;
                        t = (sz == 0) ? "R7" : (sg != 0) ? "R8" : (e != 0) ? "R6" : "R5";
                        access(1'b0, sz, sg[0], 32'(a), 32'd0, t);
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R11: reset clears all outputs, even with a request on the inputs.
        req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        chk("R11 valid", 32'(rsp_valid), 32'd0);
        chk("R11 rdata", rsp_rdata, 32'd0);
        chk("R11 err", 32'(rsp_bus_err), 32'd0);
        chk("R11 io", 32'(rsp_io_win), 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;

        // R5: fill memory with little-endian 32-bit writes, then read back everything.
        big_endian = 1'b0;
        for (int a = 0; a < DEPTH; a += 4)
            access(1'b1, 2, 1'b0, 32'(a), 32'h8100_7F00 + 32'(a * 32'h0101_0103), "R5");
        sweep_reads();

        // R6: overwrite with big-endian 16-bit writes, then read back everything.
        big_endian = 1'b1;
        for (int a = 0; a < DEPTH; a += 2)
            access(1'b1, 1, 1'b0, 32'(a), 32'h0000_80F1 ^ 32'(a * 37), "R6");
        sweep_reads();

        // R7: byte writes in both orders land on the addressed byte.
        for (int a = 0; a < DEPTH; a++) begin
            big_endian = a[0];
            access(1'b1, 0, 1'b0, 32'(a), 32'(a * 29 + 128), "R7");
        end
        sweep_reads();

        // R1, R2, R3: wrap and alignment with bus errors.
        big_endian = 1'b0;
        access(1'b0, 0, 1'b0, 32'(DEPTH + 7), 32'd0, "R1");
        access(1'b0, 0, 1'b1, 32'h8000_0011, 32'd0, "R1");
        access(1'b0, 2, 1'b0, 32'h0000_000D, 32'd0, "R2");
        access(1'b0, 3, 1'b0, 32'h0000_0016, 32'd0, "R2");
        access(1'b0, 1, 1'b1, 32'h0000_0009, 32'd0, "R2");
        access(1'b0, 2, 1'b0, 32'(DEPTH - 4), 32'd0, "R3");

        // R4: faulting writes still write the masked address; read back cleanly.
        access(1'b1, 2, 1'b0, 32'(DEPTH + 34), 32'hA1B2_C3D4, "R4");
        access(1'b0, 2, 1'b0, 32'd32, 32'd0, "R4");
        big_endian = 1'b1;
        access(1'b1, 1, 1'b0, 32'h0000_0015, 32'h0000_5AA5, "R4");
        access(1'b0, 1, 1'b0, 32'h0000_0014, 32'd0, "R4");

        // R9: I/O window only for byte writes strictly above the base.
        access(1'b1, 0, 1'b0, 32'h0500_0001, 32'h0000_0041, "R9");
        access(1'b0, 0, 1'b0, 32'h0000_0001, 32'd0, "R4");
        access(1'b1, 0, 1'b0, 32'h0500_0000, 32'h0000_0042, "R9");
        access(1'b0, 0, 1'b0, 32'h0500_0002, 32'd0, "R9");
        access(1'b1, 1, 1'b0, 32'h0600_0000, 32'h0000_1234, "R9");
        access(1'b1, 2, 1'b0, 32'hF000_0000, 32'h1234_5678, "R9");
        access(1'b0, 2, 1'b0, 32'd0, 32'd0, "R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule